// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Variable Page Sizes

This block is a fully associative address translation cache for a processor whose miss handling is done by software. Every slot holds a virtual page-pair tag, a page-size mask, an address-space identifier, a global flag and two physical frames: one for the even page of the pair and one for the odd page. Each frame has a 3-bit cache attribute, a dirty bit and a valid bit. The lookup port is purely combinational. It takes a 32-bit virtual address and an identifier and returns whether a slot matched, plus the frame and attributes of the selected half. It also flags addresses that fall in the uncached window.

Software manages the contents through four other ports. The probe port reports which slot matches an address. The indexed write port fills a slot on the next clock edge. The indexed read port returns a slot's contents in packed form. The flush command empties all slots at once. Six counters record lookup activity, split by reads and writes and by hits and misses. Page-table walking, fault handling and cache control belong to the surrounding logic.

Top module: `tlb_assoc`

## Requirements
- R1: A slot matches an address when the address bits [31:13], masked by the slot's mask bits [17:2] (mask bit k clears compare of address bit 11+k), equal the slot's 19-bit tag masked the same way, and the slot has been filled since the last reset or flush.
- R2: A match also needs either the slot's global flag set or the lookup identifier equal to the slot's identifier.
- R3: The odd frame is selected when address bit (12 + number of set mask bits in [17:2]) is 1, and the even frame otherwise. Frame outputs are zero on a miss.
- R4: When several slots match, the lookup and the probe both use the lowest-numbered one.
- R5: The probe output gives the matching slot index. When no slot matches, it gives all ones.
- R6: The indexed read returns each frame as a 32-bit word with frame number in [31:6], cache attribute in [5:3], dirty in [2], valid in [1] and the global flag in [0]. It returns the mask shifted left by 11 bits in a 32-bit word, plus the tag and the identifier. An index at or above the slot count reads as zero.
- R7: An indexed write changes the slot at the next rising clock edge. A write index at or above the slot count changes nothing and raises the write-error output in the same cycle.
- R8: A flush empties every slot in one cycle. A write in the same cycle as a flush is discarded.
- R9: The uncached flag is 1 exactly when lookup address bits 31 and 29 are both 1.
- R10: Each cycle with the lookup enable high increments the read or write access counter, selected by the write qualifier, and also the matching hit or miss counter.
- R11: Reset empties all slots, clears stored contents and zeroes all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_en | input | 1 | Count this lookup as an access |
| lk_wr | input | 1 | The counted access is a store |
| lk_hit | output | 1 | A slot matched |
| lk_pfn | output | 26 | Selected physical frame number |
| lk_cattr | output | 3 | Selected cache attribute |
| lk_dirty | output | 1 | Selected dirty bit |
| lk_valid | output | 1 | Selected valid bit |
| lk_uncached | output | 1 | Address lies in the uncached window |
| pr_va | input | 32 | Probe virtual address |
| pr_asid | input | ASID_W | Probe identifier |
| pr_idx | output | IDX_W | Matching slot or all ones |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_tag | input | 19 | Tag, address bits [31:13] |
| wr_mask | input | 18 | Page mask, bit k covers address bit 11+k |
| wr_asid | input | ASID_W | Slot identifier |
| wr_glob | input | 1 | Global flag |
| wr_frm0 | input | 31 | Even frame {pfn, cattr, dirty, valid} |
| wr_frm1 | input | 31 | Odd frame {pfn, cattr, dirty, valid} |
| wr_err | output | 1 | Write index out of range |
| rd_idx | input | IDX_W | Slot to read |
| rd_tag | output | 19 | Stored tag |
| rd_mask | output | 32 | Mask shifted left by 11 |
| rd_asid | output | ASID_W | Stored identifier |
| rd_lo0 | output | 32 | Packed even frame |
| rd_lo1 | output | 32 | Packed odd frame |
| flush | input | 1 | Empty all slots |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_rd_acc | output | CNT_W | Read accesses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wr_acc | output | CNT_W | Write accesses |

## Verification
Some properties are checked on every cycle. The probe and the lookup must agree whenever they see the same address and identifier. A probe index is always in range or all ones. No slot matches in the cycle after a flush. The hit and miss counters always add up to the access counter, and the read access counter steps by one per counted read. Other behaviour only the bench scenarios can show: the exact frame and attributes returned, the even/odd choice under a widened mask, lowest-slot priority, the timing of writes, discarded out-of-range and flush-coincident writes, and the packed readback layout.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_en,
  input  logic              lk_wr,
  output logic              lk_hit,
  output logic [25:0]       lk_pfn,
  output logic [2:0]        lk_cattr,
  output logic              lk_dirty,
  output logic              lk_valid,
  output logic              lk_uncached,
  input  logic [31:0]       pr_va,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [18:0]       wr_tag,
  input  logic [17:0]       wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [30:0]       wr_frm0,
  input  logic [30:0]       wr_frm1,
  output logic              wr_err,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [18:0]       rd_tag,
  output logic [31:0]       rd_mask,
  output logic [ASID_W-1:0] rd_asid,
  output logic [31:0]       rd_lo0,
  output logic [31:0]       rd_lo1,
  input  logic              flush,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_rd_acc,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_wr_acc
);

  localparam int SEL_W = IDX_W - 1;
  localparam logic [IDX_W-1:0] NENT = IDX_W'(ENTRIES);

  typedef struct packed {
    logic              live;
    logic [18:0]       tag;
    logic [17:0]       mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [30:0]       f0;
    logic [30:0]       f1;
  } ent_t;

  ent_t tbl [ENTRIES];

  function automatic logic ent_hit(ent_t e, logic [31:0] va, logic [ASID_W-1:0] as);
    logic [18:0] keep;
    keep = ~{3'b000, e.mask[17:2]};
    return e.live && ((va[31:13] & keep) == (e.tag & keep)) && (e.glob || as == e.asid);
  endfunction

  function automatic logic odd_half(ent_t e, logic [31:0] va);
    int pos;
    pos = 12 + $countones(e.mask[17:2]);
    return va[pos];
  endfunction

  logic [SEL_W-1:0] lk_sel;
  logic [30:0]      lk_frm;

  always_comb begin
    lk_hit = 1'b0;
    lk_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_hit(tbl[i], lk_va, lk_asid)) begin
        lk_hit = 1'b1;
        lk_sel = SEL_W'(i);
      end
    end
    lk_frm = '0;
    if (lk_hit) lk_frm = odd_half(tbl[lk_sel], lk_va) ? tbl[lk_sel].f1 : tbl[lk_sel].f0;
  end

  assign {lk_pfn, lk_cattr, lk_dirty, lk_valid} = lk_frm;
  assign lk_uncached = (lk_va & 32'hA000_0000) == 32'hA000_0000;

  always_comb begin
    pr_idx = '1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ent_hit(tbl[i], pr_va, pr_asid)) pr_idx = IDX_W'(i);
  end

  assign wr_err = wr_en && (wr_idx >= NENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i].live <= 1'b0;
    end else if (wr_en && !wr_err) begin
      tbl[wr_idx[SEL_W-1:0]] <= {1'b1, wr_tag, wr_mask, wr_asid, wr_glob, wr_frm0, wr_frm1};
    end
  end

  logic rd_ok;
  ent_t rd_e;
  assign rd_ok = rd_idx < NENT;
  assign rd_e  = rd_ok ? tbl[rd_idx[SEL_W-1:0]] : '0;
  assign rd_tag  = rd_e.tag;
  assign rd_asid = rd_e.asid;
  assign rd_mask = {3'b000, rd_e.mask, 11'b0};
  assign rd_lo0  = {rd_e.f0, rd_e.glob};
  assign rd_lo1  = {rd_e.f1, rd_e.glob};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_rd_hit  <= '0;
      cnt_rd_miss <= '0;
      cnt_rd_acc  <= '0;
      cnt_wr_hit  <= '0;
      cnt_wr_miss <= '0;
      cnt_wr_acc  <= '0;
    end else if (lk_en) begin
      if (lk_wr) begin
        cnt_wr_acc <= cnt_wr_acc + 1'b1;
        if (lk_hit) cnt_wr_hit  <= cnt_wr_hit + 1'b1;
        else        cnt_wr_miss <= cnt_wr_miss + 1'b1;
      end else begin
        cnt_rd_acc <= cnt_rd_acc + 1'b1;
        if (lk_hit) cnt_rd_hit  <= cnt_rd_hit + 1'b1;
        else        cnt_rd_miss <= cnt_rd_miss + 1'b1;
      end
    end
  end

  // R5
  probe_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_va == lk_va && pr_asid == lk_asid) |-> (lk_hit == (pr_idx != '1)));

  // R5
  probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_idx != '1) |-> (pr_idx < NENT));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && pr_idx == '1));

  // R10
  rd_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(cnt_rd_hit + cnt_rd_miss) == cnt_rd_acc);

  // R10
  wr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(cnt_wr_hit + cnt_wr_miss) == cnt_wr_acc);

  // R10
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !lk_wr) |=> cnt_rd_acc == CNT_W'($past(cnt_rd_acc) + 1'b1));

endmodule

// File: tb/tlb_assoc_tb_top.sv
`timescale 1ns/1ps
module tlb_assoc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] lk_va = '0, pr_va = '0;
  logic [7:0]  lk_asid = '0, pr_asid = '0, wr_asid = '0, rd_asid;
  logic lk_en = 0, lk_wr = 0, wr_en = 0, wr_glob = 0, flush = 0;
  logic lk_hit, lk_dirty, lk_valid, lk_uncached, wr_err;
  logic [25:0] lk_pfn;
  logic [2:0]  lk_cattr;
  logic [4:0]  pr_idx, wr_idx = '0, rd_idx = '0;
  logic [18:0] wr_tag = '0, rd_tag;
  logic [17:0] wr_mask = '0;
  logic [30:0] wr_frm0 = '0, wr_frm1 = '0;
  logic [31:0] rd_mask, rd_lo0, rd_lo1;
  logic [15:0] c_rh, c_rm, c_ra, c_wh, c_wm, c_wa;

  tlb_assoc dut_i (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_asid(lk_asid), .lk_en(lk_en), .lk_wr(lk_wr),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_cattr(lk_cattr), .lk_dirty(lk_dirty), .lk_valid(lk_valid),
    .lk_uncached(lk_uncached), .pr_va(pr_va), .pr_asid(pr_asid), .pr_idx(pr_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_mask(wr_mask), .wr_asid(wr_asid),
    .wr_glob(wr_glob), .wr_frm0(wr_frm0), .wr_frm1(wr_frm1), .wr_err(wr_err),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_mask(rd_mask), .rd_asid(rd_asid), .rd_lo0(rd_lo0),
    .rd_lo1(rd_lo1), .flush(flush), .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_rd_acc(c_ra),
    .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm), .cnt_wr_acc(c_wa));

  int n_cmp = 0, n_bad = 0;
  int e_rh = 0, e_rm = 0, e_ra = 0, e_wh = 0, e_wm = 0, e_wa = 0;
  bit done = 0;

  logic [18:0] sh_tag [16];
  logic [17:0] sh_mask [16];
  logic [7:0]  sh_asid [16];
  logic        sh_g [16];
  logic [30:0] sh_f0 [16], sh_f1 [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [30:0] frm(logic [25:0] p, logic [2:0] c, logic d, logic v);
    return {p, c, d, v};
  endfunction

  task automatic rdchk(input int i);
    rd_idx = 5'(i);
    #1;
    chk("R6 tag", 32'(rd_tag), 32'(sh_tag[i]));
    chk("R6 mask<<11", rd_mask, {3'b0, sh_mask[i], 11'b0});
    chk("R6 asid", 32'(rd_asid), 32'(sh_asid[i]));
    chk("R6 even word", rd_lo0, {sh_f0[i], sh_g[i]});
    chk("R6 odd word", rd_lo1, {sh_f1[i], sh_g[i]});
  endtask

  task automatic wr(input logic [4:0] idx, input logic [18:0] t, input logic [17:0] m,
                    input logic [7:0] a, input logic g, input logic [30:0] f0, input logic [30:0] f1);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_tag = t; wr_mask = m; wr_asid = a; wr_glob = g;
    wr_frm0 = f0; wr_frm1 = f1; rd_idx = idx;
    #1;
    chk("R7 wr_err", 32'(wr_err), 32'(idx >= 5'd16));
    if (idx < 5'd16) chk("R7 not before edge", 32'(rd_tag), 32'(sh_tag[idx[3:0]]));
    else chk("R6 out of range read", rd_lo0, 32'h0);
    @(negedge clk);
    wr_en = 0;
    if (idx < 5'd16) begin
      sh_tag[idx[3:0]] = t; sh_mask[idx[3:0]] = m; sh_asid[idx[3:0]] = a;
      sh_g[idx[3:0]] = g; sh_f0[idx[3:0]] = f0; sh_f1[idx[3:0]] = f1;
      rdchk(int'(idx));
    end
  endtask

  task automatic acc(input string req, input logic [31:0] va, input logic [7:0] as,
                     input logic w, input logic [4:0] eidx, input logic [30:0] ef);
    logic eh;
    eh = (eidx != 5'h1F);
    @(negedge clk);
    lk_va = va; lk_asid = as; pr_va = va; pr_asid = as; lk_en = 1; lk_wr = w;
    #1;
    chk({req, " hit"}, 32'(lk_hit), 32'(eh));
    chk({req, " frame"}, {1'b0, lk_pfn, lk_cattr, lk_dirty, lk_valid}, {1'b0, eh ? ef : 31'h0});
    chk("R5 probe", 32'(pr_idx), 32'(eidx));
    if (w) begin e_wa++; if (eh) e_wh++; else e_wm++; end
    else   begin e_ra++; if (eh) e_rh++; else e_rm++; end
    @(negedge clk);
    lk_en = 0;
  endtask

  task automatic cntchk();
    #1;
    chk("R10 rd hit", 32'(c_rh), 32'(e_rh));
    chk("R10 rd miss", 32'(c_rm), 32'(e_rm));
    chk("R10 rd acc", 32'(c_ra), 32'(e_ra));
    chk("R10 wr hit", 32'(c_wh), 32'(e_wh));
    chk("R10 wr miss", 32'(c_wm), 32'(e_wm));
    chk("R10 wr acc", 32'(c_wa), 32'(e_wa));
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sh_tag[i] = '0; sh_mask[i] = '0; sh_asid[i] = '0; sh_g[i] = 0; sh_f0[i] = '0; sh_f1[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11: reset state
    chk("R11 no hit", 32'(lk_hit), 0);
    chk("R11 probe", 32'(pr_idx), 32'h1F);
    cntchk();
    rdchk(0);

    // fill all slots
    for (int i = 0; i < 16; i++)
      wr(5'(i), 19'(i + 1), 18'h0, 8'(i * 3 + 1), i == 3,
         frm(26'h100 + 26'(i), 3'(i), i[0], 1'b1),
         frm(26'h200 + 26'(i), 3'(i + 1), !i[0], i[1]));

    // R1 R2 R3 sweep
    for (int i = 0; i < 16; i++)
      for (int h = 0; h < 2; h++) begin
        acc("R1 R3 own asid", {sh_tag[i], 1'(h), 12'h5A5}, sh_asid[i], 1'(h), 5'(i),
            h ? sh_f1[i] : sh_f0[i]);
        acc("R2 foreign asid", {sh_tag[i], 1'(h), 12'h0F0}, 8'hF0, 1'(h),
            (i == 3) ? 5'd3 : 5'h1F, h ? sh_f1[3] : sh_f0[3]);
      end
    cntchk();

    // R1 R3 16K pages in slot 5
    wr(5'd5, 19'h40, 18'h0C, 8'h33, 1'b0, frm(26'h3AAAA, 3'd2, 1, 1), frm(26'h3BBBB, 3'd3, 0, 1));
    chk("R6 mask 16K", rd_mask, 32'h6000);
    acc("R3 masked even", 32'h0008_2000, 8'h33, 0, 5'd5, sh_f0[5]);
    acc("R3 masked odd", 32'h0008_6000, 8'h33, 1, 5'd5, sh_f1[5]);
    acc("R3 masked base", 32'h0008_0000, 8'h33, 0, 5'd5, sh_f0[5]);
    acc("R1 outside page", 32'h0008_8000, 8'h33, 0, 5'h1F, '0);

    // R4 priority
    wr(5'd12, 19'h77, 18'h0, 8'h55, 1'b0, frm(26'hC0C, 3'd1, 0, 1), frm(26'hC1C, 3'd1, 0, 1));
    wr(5'd9,  19'h77, 18'h0, 8'h55, 1'b0, frm(26'h909, 3'd4, 1, 1), frm(26'h919, 3'd4, 1, 1));
    acc("R4 lowest wins", {19'h77, 1'b0, 12'h0}, 8'h55, 0, 5'd9, sh_f0[9]);
    wr(5'd9,  19'h78, 18'h0, 8'h55, 1'b0, frm(26'h909, 3'd4, 1, 1), frm(26'h919, 3'd4, 1, 1));
    acc("R4 next slot", {19'h77, 1'b1, 12'h0}, 8'h55, 1, 5'd12, sh_f1[12]);

    // R7 out-of-range write
    wr(5'd16, 19'h99, 18'h0, 8'h00, 1'b0, frm(26'h1, 0, 0, 1), frm(26'h2, 0, 0, 1));
    wr(5'd31, 19'h99, 18'h0, 8'h00, 1'b1, frm(26'h1, 0, 0, 1), frm(26'h2, 0, 0, 1));
    acc("R7 ignored write", {19'h99, 1'b0, 12'h0}, 8'h00, 0, 5'h1F, '0);
    for (int i = 0; i < 16; i++) rdchk(i);

    // R9 uncached window
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      lk_va = {3'(t), 29'h0123456};
      #1;
      chk("R9 uncached", 32'(lk_uncached), 32'(t[2] & t[0]));
    end
    cntchk();

    // R8 flush with coincident write
    @(negedge clk);
    flush = 1; wr_en = 1; wr_idx = 5'd1; wr_tag = 19'h123; wr_mask = '0; wr_asid = 8'h01;
    wr_glob = 1; wr_frm0 = frm(26'h5, 0, 0, 1); wr_frm1 = frm(26'h6, 0, 0, 1);
    @(negedge clk);
    flush = 0; wr_en = 0;
    rdchk(1);
    acc("R8 flushed write", {19'h123, 1'b0, 12'h0}, 8'h01, 0, 5'h1F, '0);
    for (int i = 0; i < 16; i++)
      acc("R8 flushed", {sh_tag[i], 1'b0, 12'h0}, sh_asid[i], 1'(i & 1), 5'h1F, '0);
    cntchk();
    finish_run();
  end
endmodule